// File: doc/BRIEF.md
# Character Panel Position-to-Address Mapper

This block sits between the refresh scanner of a 16-column, 2-row character panel and the 32-byte display data store. Each cycle the scanner may present a common (scan line) index and a column. One cycle later the block returns three things: the logical display address the software sees for that cell, the physical storage location that actually holds the byte, and the glyph row to fetch from the character pattern. Three layouts are supported. The sequential layout places row 1 at 0x10..0x1F. The split layout places row 1 at 0x40..0x4F, and those addresses are folded onto storage locations 16..31. The double-height layout makes the panel a single line at 0x00..0x0F and ignores the split selection.

A second path runs the other way. An address counter value is turned into a visible panel position for cursor placement. Addresses outside the active layout report not-visible, so no cursor is drawn.

The layout in force is held in a small state machine with the states `LAY_SEQ`, `LAY_SPLIT` and `LAY_TALL`. Every cycle it takes the transition `T_TO_TALL` when double height is requested. Otherwise it takes `T_TO_SPLIT` when the split select is high, and `T_TO_SEQ` in the remaining case. Staying in the same layout is simply the matching transition back to the current state. Requests, positions and the address counter are registered on the same edge as the layout, so every output reflects the inputs sampled at the previous rising edge.

Top module: `disp_addr_map`

## Requirements
- R1: While reset is high, and after reset until the first request, map_vld_o is 0, addr_o, phys_o and glyph_o are 0, and the cursor outputs report visible at row 0, column 0 (the address counter register clears to 0 and the layout to sequential).
- R2: Sequential layout (dbl_i=0, split_i=0): scan line index L (0..15) selects row L/8 and glyph row L%8. For column C, addr_o = 16*row + C.
- R3: Split layout (dbl_i=0, split_i=1): addr_o = 64*row + C, so row 1 occupies 0x40..0x4F. The glyph row is L%8.
- R4: phys_o = 16*row + C in the sequential and split layouts, and phys_o = C in the double-height layout. This means split addresses 0x40..0x4F land on locations 16..31.
- R5: Double-height layout (dbl_i=1): addr_o = C for every scan line index 0..15, whatever the value of split_i.
- R6: In double height, glyph_o = L/2, so each glyph row covers two consecutive scan lines.
- R7: map_vld_o is 1 only when scan_req_i was 1 and col_i < 16 at the sampling edge. When map_vld_o is 0, addr_o, phys_o and glyph_o are all 0.
- R8: Reverse map in the sequential layout: ac_i < 0x20 is visible, with row ac/16 and column ac%16. Any larger value is not visible.
- R9: Reverse map in the split layout: 0x00..0x0F is row 0 and 0x40..0x4F is row 1, with column ac%16. Every other value, 0x10..0x3F included, is not visible.
- R10: Reverse map in double height: only 0x00..0x0F is visible, always on row 0. When not visible, cur_row_o and cur_col_o are 0.
- R11: Every output reflects the inputs sampled at the previous rising clock edge, including a layout change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| split_i | input | 1 | Selects the split layout (row 1 at 0x40) |
| dbl_i | input | 1 | Double-height enable; overrides split_i |
| scan_req_i | input | 1 | A position is presented this cycle |
| line_i | input | 4 | Scan line (common) index 0..15 |
| col_i | input | 5 | Column; values 16..31 are out of range |
| ac_i | input | 7 | Address counter value for cursor lookup |
| map_vld_o | output | 1 | Forward result valid |
| addr_o | output | 7 | Logical display address |
| phys_o | output | 5 | Physical storage location 0..31 |
| glyph_o | output | 3 | Glyph row to fetch |
| cur_vis_o | output | 1 | Cursor position is on the panel |
| cur_row_o | output | 1 | Cursor row |
| cur_col_o | output | 4 | Cursor column |

## Verification
The hardest case to reach is a layout change that lands in the same cycle as a request. Both the new layout and the position must be taken from the same edge, or the result is computed under the old layout. The stimulus toggles split_i and dbl_i on consecutive requests and tests the same cell under each layout. It also holds dbl_i high while split_i flips, to show the split select has no effect. The address counter is swept over all 128 values in each layout, so the gap 0x10..0x3F of the split layout and the edges at 0x0F, 0x1F, 0x40 and 0x4F are all covered.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
    typedef enum logic [1:0] {
        LAY_SEQ   = 2'd0,
        LAY_SPLIT = 2'd1,
        LAY_TALL  = 2'd2
    } layout_e;
endpackage

// File: rtl/dmap_layout_fsm.sv
module dmap_layout_fsm
    import dmap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    split_i,
    input  logic    dbl_i,
    output layout_e state_o
);
    layout_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LAY_SEQ;
        else     state_q <= state_d;
    end

    // transitions: T_TO_TALL has priority, then T_TO_SPLIT, else T_TO_SEQ
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAY_SEQ: begin
                if (dbl_i)        state_d = LAY_TALL;
                else if (split_i) state_d = LAY_SPLIT;
                else              state_d = LAY_SEQ;
            end
            LAY_SPLIT: begin
                if (dbl_i)        state_d = LAY_TALL;
                else if (split_i) state_d = LAY_SPLIT;
                else              state_d = LAY_SEQ;
            end
            LAY_TALL: begin
                if (dbl_i)        state_d = LAY_TALL;
                else if (split_i) state_d = LAY_SPLIT;
                else              state_d = LAY_SEQ;
            end
            default:              state_d = LAY_SEQ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/dmap_fwd.sv
module dmap_fwd
    import dmap_pkg::*;
#(
    parameter int COLS      = 16,
    parameter int GLY_LINES = 8,
    parameter int ROW2_BASE = 64,
    parameter int ADDR_W    = 7,
    localparam int CI_W     = $clog2(COLS),
    localparam int COL_W    = CI_W + 1,
    localparam int GLY_W    = $clog2(GLY_LINES),
    localparam int LINE_W   = GLY_W + 1,
    localparam int PHYS_W   = CI_W + 1
) (
    input  layout_e             lay,
    input  logic                req,
    input  logic [LINE_W-1:0]   line,
    input  logic [COL_W-1:0]    col,
    output logic                vld,
    output logic [ADDR_W-1:0]   addr,
    output logic [PHYS_W-1:0]   phys,
    output logic [GLY_W-1:0]    glyph
);
    logic              in_range;
    logic              row;
    logic [CI_W-1:0]   cidx;
    logic [ADDR_W-1:0] cext;

    assign in_range = (col < COL_W'(COLS));
    assign row      = line[LINE_W-1];
    assign cidx     = col[CI_W-1:0];
    assign cext     = ADDR_W'(cidx);

    always_comb begin
        vld   = req && in_range;
        addr  = '0;
        phys  = '0;
        glyph = '0;
        if (vld) begin
            unique case (lay)
                LAY_SEQ: begin
                    addr  = row ? (ADDR_W'(COLS) + cext) : cext;
                    phys  = {row, cidx};
                    glyph = line[GLY_W-1:0];
                end
                LAY_SPLIT: begin
                    addr  = row ? (ADDR_W'(ROW2_BASE) + cext) : cext;
                    phys  = {row, cidx};
                    glyph = line[GLY_W-1:0];
                end
                LAY_TALL: begin
                    addr  = cext;
                    phys  = {1'b0, cidx};
                    glyph = line[LINE_W-1:1];
                end
                default: begin
                    addr  = '0;
                    phys  = '0;
                    glyph = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dmap_rev.sv
module dmap_rev
    import dmap_pkg::*;
#(
    parameter int COLS      = 16,
    parameter int ROW2_BASE = 64,
    parameter int ADDR_W    = 7,
    localparam int CI_W     = $clog2(COLS)
) (
    input  layout_e           lay,
    input  logic [ADDR_W-1:0] ac,
    output logic              vis,
    output logic              row,
    output logic [CI_W-1:0]   col
);
    localparam logic [ADDR_W-1:0] ONE_LINE = ADDR_W'(COLS);
    localparam logic [ADDR_W-1:0] TWO_LINE = ADDR_W'(2 * COLS);
    localparam logic [ADDR_W-1:0] R2_LO    = ADDR_W'(ROW2_BASE);
    localparam logic [ADDR_W-1:0] R2_HI    = ADDR_W'(ROW2_BASE + COLS);

    always_comb begin
        vis = 1'b0;
        row = 1'b0;
        unique case (lay)
            LAY_SEQ: begin
                vis = (ac < TWO_LINE);
                row = (ac >= ONE_LINE);
            end
            LAY_SPLIT: begin
                if (ac < ONE_LINE) begin
                    vis = 1'b1;
                end else if (ac >= R2_LO && ac < R2_HI) begin
                    vis = 1'b1;
                    row = 1'b1;
                end
            end
            LAY_TALL:  vis = (ac < ONE_LINE);
            default:   vis = 1'b0;
        endcase
        if (!vis) row = 1'b0;
        col = vis ? ac[CI_W-1:0] : '0;
    end
endmodule

// File: rtl/disp_addr_map.sv
module disp_addr_map
    import dmap_pkg::*;
#(
    parameter int COLS      = 16,
    parameter int GLY_LINES = 8,
    parameter int ROW2_BASE = 64,
    parameter int ADDR_W    = 7,
    localparam int CI_W     = $clog2(COLS),
    localparam int COL_W    = CI_W + 1,
    localparam int GLY_W    = $clog2(GLY_LINES),
    localparam int LINE_W   = GLY_W + 1,
    localparam int PHYS_W   = CI_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              split_i,
    input  logic              dbl_i,
    input  logic              scan_req_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [ADDR_W-1:0] ac_i,
    output logic              map_vld_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [PHYS_W-1:0] phys_o,
    output logic [GLY_W-1:0]  glyph_o,
    output logic              cur_vis_o,
    output logic              cur_row_o,
    output logic [CI_W-1:0]   cur_col_o
);
    layout_e           lay;
    logic              req_q;
    logic [LINE_W-1:0] line_q;
    logic [COL_W-1:0]  col_q;
    logic [ADDR_W-1:0] ac_q;

    logic              f_vld;
    logic [ADDR_W-1:0] f_addr;
    logic [PHYS_W-1:0] f_phys;
    logic [GLY_W-1:0]  f_glyph;
    logic              r_vis;
    logic              r_row;
    logic [CI_W-1:0]   r_col;

    dmap_layout_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .split_i (split_i),
        .dbl_i   (dbl_i),
        .state_o (lay)
    );

    // sample position and counter on the same edge as the layout
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            line_q <= '0;
            col_q  <= '0;
            ac_q   <= '0;
        end else begin
            req_q  <= scan_req_i;
            line_q <= line_i;
            col_q  <= col_i;
            ac_q   <= ac_i;
        end
    end

    dmap_fwd #(
        .COLS(COLS), .GLY_LINES(GLY_LINES), .ROW2_BASE(ROW2_BASE), .ADDR_W(ADDR_W)
    ) u_fwd (
        .lay   (lay),
        .req   (req_q),
        .line  (line_q),
        .col   (col_q),
        .vld   (f_vld),
        .addr  (f_addr),
        .phys  (f_phys),
        .glyph (f_glyph)
    );

    dmap_rev #(
        .COLS(COLS), .ROW2_BASE(ROW2_BASE), .ADDR_W(ADDR_W)
    ) u_rev (
        .lay (lay),
        .ac  (ac_q),
        .vis (r_vis),
        .row (r_row),
        .col (r_col)
    );

    // output process
    always_comb begin
        map_vld_o = f_vld;
        addr_o    = f_addr;
        phys_o    = f_phys;
        glyph_o   = f_glyph;
        cur_vis_o = r_vis;
        cur_row_o = r_row;
        cur_col_o = r_col;
    end
endmodule

// File: rtl/dmap_checks.sv
module dmap_checks (
    input logic       clk,
    input logic       rst,
    input logic       split_i,
    input logic       dbl_i,
    input logic       scan_req_i,
    input logic [3:0] line_i,
    input logic [4:0] col_i,
    input logic [6:0] ac_i,
    input logic       map_vld_o,
    input logic [6:0] addr_o,
    input logic [4:0] phys_o,
    input logic [2:0] glyph_o,
    input logic       cur_vis_o,
    input logic       cur_row_o,
    input logic [3:0] cur_col_o
);
    assert_vld_req_R7: assert property (@(posedge clk) disable iff (rst)
        map_vld_o |-> ($past(scan_req_i) && $past(col_i) < 5'd16));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !map_vld_o |-> (addr_o == 7'd0 && phys_o == 5'd0 && glyph_o == 3'd0));

    assert_fold_low_R4: assert property (@(posedge clk) disable iff (rst)
        map_vld_o |-> (phys_o[3:0] == addr_o[3:0]));

    assert_split_hi_R3: assert property (@(posedge clk) disable iff (rst)
        (map_vld_o && $past(split_i && !dbl_i) && $past(line_i[3]))
            |-> (addr_o[6] && phys_o[4]));

    assert_tall_low_R5: assert property (@(posedge clk) disable iff (rst)
        (map_vld_o && $past(dbl_i)) |-> (addr_o[6:4] == 3'd0));

    assert_glyph_norm_R2: assert property (@(posedge clk) disable iff (rst)
        (map_vld_o && !$past(dbl_i)) |-> (glyph_o == $past(line_i[2:0])));

    assert_glyph_tall_R6: assert property (@(posedge clk) disable iff (rst)
        (map_vld_o && $past(dbl_i)) |-> (glyph_o == $past(line_i[3:1])));

    assert_rev_split_R9: assert property (@(posedge clk) disable iff (rst)
        (cur_vis_o && $past(split_i && !dbl_i)) |-> (cur_row_o == $past(ac_i[6])));

    assert_rev_tall_R10: assert property (@(posedge clk) disable iff (rst)
        (cur_vis_o && $past(dbl_i)) |-> !cur_row_o);

    assert_rev_hidden_R10: assert property (@(posedge clk) disable iff (rst)
        !cur_vis_o |-> (!cur_row_o && cur_col_o == 4'd0));
endmodule

bind disp_addr_map dmap_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .split_i    (split_i),
    .dbl_i      (dbl_i),
    .scan_req_i (scan_req_i),
    .line_i     (line_i),
    .col_i      (col_i),
    .ac_i       (ac_i),
    .map_vld_o  (map_vld_o),
    .addr_o     (addr_o),
    .phys_o     (phys_o),
    .glyph_o    (glyph_o),
    .cur_vis_o  (cur_vis_o),
    .cur_row_o  (cur_row_o),
    .cur_col_o  (cur_col_o)
);

// File: tb/disp_addr_map_tb.sv
`timescale 1ns/1ps
module disp_addr_map_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       split_i = 1'b0;
    logic       dbl_i = 1'b0;
    logic       scan_req_i = 1'b0;
    logic [3:0] line_i = '0;
    logic [4:0] col_i = '0;
    logic [6:0] ac_i = '0;
    logic       map_vld_o;
    logic [6:0] addr_o;
    logic [4:0] phys_o;
    logic [2:0] glyph_o;
    logic       cur_vis_o;
    logic       cur_row_o;
    logic [3:0] cur_col_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int    vld, addr, phys, glyph, vis, row, col;
        string tag;
        string rtag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    disp_addr_map u_dut (
        .clk(clk), .rst(rst), .split_i(split_i), .dbl_i(dbl_i),
        .scan_req_i(scan_req_i), .line_i(line_i), .col_i(col_i), .ac_i(ac_i),
        .map_vld_o(map_vld_o), .addr_o(addr_o), .phys_o(phys_o), .glyph_o(glyph_o),
        .cur_vis_o(cur_vis_o), .cur_row_o(cur_row_o), .cur_col_o(cur_col_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic drive(input int ln, input int cl, input int ac,
                         input bit sp, input bit db, input bit rq);
        exp_t e;
        int   r;
        @(negedge clk);
        line_i = 4'(ln); col_i = 5'(cl); ac_i = 7'(ac);
        split_i = sp; dbl_i = db; scan_req_i = rq;
        e.vld = (rq && cl < 16) ? 1 : 0;
        e.addr = 0; e.phys = 0; e.glyph = 0;
        if (db) begin
            e.tag = "R5/R6";
            if (e.vld == 1) begin
                e.addr = cl; e.phys = cl; e.glyph = ln / 2;
            end
        end else begin
            r = ln / 8;
            e.tag = sp ? "R3/R4" : "R2/R4";
            if (e.vld == 1) begin
                e.addr = (sp ? 64 : 16) * r + cl;
                e.phys = 16 * r + cl;
                e.glyph = ln % 8;
            end
        end
        if (e.vld == 0) e.tag = "R7";
        e.vis = 0; e.row = 0; e.col = 0;
        if (db) begin
            e.rtag = "R10";
            if (ac < 16) begin e.vis = 1; e.col = ac; end
        end else if (sp) begin
            e.rtag = "R9";
            if (ac < 16) begin e.vis = 1; e.col = ac; end
            else if (ac >= 64 && ac < 80) begin e.vis = 1; e.row = 1; e.col = ac - 64; end
        end else begin
            e.rtag = "R8";
            if (ac < 32) begin e.vis = 1; e.row = ac / 16; e.col = ac % 16; end
        end
        sb.push_back(e);
    endtask

    // monitor: one result per edge, sampled after the edge (R11 latency)
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " R11 vld"},   int'(map_vld_o), e.vld);
            chk({e.tag, " R11 addr"},  int'(addr_o),    e.addr);
            chk({e.tag, " phys"},      int'(phys_o),    e.phys);
            chk({e.tag, " glyph"},     int'(glyph_o),   e.glyph);
            chk({e.rtag, " vis"},      int'(cur_vis_o), e.vis);
            chk({e.rtag, " row"},      int'(cur_row_o), e.row);
            chk({e.rtag, " col"},      int'(cur_col_o), e.col);
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        scan_req_i = 1'b1; col_i = 5'd3; ac_i = 7'd90;
        @(negedge clk);
        chk("R1 vld in reset",  int'(map_vld_o), 0);
        chk("R1 addr in reset", int'(addr_o), 0);
        chk("R1 cursor vis",    int'(cur_vis_o), 1);
        chk("R1 cursor pos",    int'({cur_row_o, cur_col_o}), 0);
        scan_req_i = 1'b0; ac_i = '0; col_i = '0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 vld after reset", int'(map_vld_o), 0);
        chk("R1 phys after reset", int'(phys_o), 0);

        // full sweep of every cell under each layout
        for (int m = 0; m < 3; m++)
            for (int ln = 0; ln < 16; ln++)
                for (int cl = 0; cl < 16; cl++)
                    drive(ln, cl, (ln * 16 + cl) % 128, m == 1, m == 2, 1'b1);

        // R5: split select ignored under double height
        for (int ln = 0; ln < 16; ln++) begin
            drive(ln, 9, 15, 1'b1, 1'b1, 1'b1);
            drive(ln, 9, 16, 1'b0, 1'b1, 1'b1);
        end

        // R11: layout flips on consecutive requests for the same cell
        for (int k = 0; k < 6; k++) begin
            drive(12, 5, 69, 1'b0, 1'b0, 1'b1);
            drive(12, 5, 69, 1'b1, 1'b0, 1'b1);
            drive(12, 5, 69, 1'b1, 1'b1, 1'b1);
            drive(12, 5, 69, 1'b0, 1'b0, 1'b1);
        end

        // R7: out-of-range columns and idle cycles
        for (int cl = 16; cl < 32; cl++) drive(3, cl, 0, 1'b0, 1'b0, 1'b1);
        drive(9, 4, 0, 1'b1, 1'b0, 1'b0);
        drive(9, 4, 0, 1'b0, 1'b1, 1'b0);

        // R8 R9 R10: address counter sweep per layout
        for (int m = 0; m < 3; m++)
            for (int ac = 0; ac < 128; ac++)
                drive(ac % 16, ac % 20, ac, m == 1, m == 2, ac[0]);

        @(negedge clk); scan_req_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule